// File: doc/BRIEF.md
# Carrier-Gated Serial Transmitter

This block sends bytes as asynchronous serial frames on one output line. The line can also be gated by an on-chip PWM carrier, which suits infrared-style links. A byte enters through a one-cycle write strobe. While a frame is in flight, a busy flag is raised. The frame leaves at a bit rate set by a programmable clock divisor.

A free-running counter sets the carrier. The counter has a programmable terminal count and a programmable compare threshold. An enable bit chooses the output mode. With the bit set, the line is the logical AND of the serial bit and the carrier, so low bits stay dark and high bits and idle carry the carrier. With the bit clear, the serial bit drives the line unchanged.

Configuration goes through a plain synchronous write port. Address 0 is the divisor, 1 is the terminal count, 2 is the compare threshold and 3 is control.

Top module: `cmtx_top`

## Requirements
- R1: After reset `line_out` is 1, `tx_busy` is 0, the carrier is stopped and every configuration register is 0.
- R2: With control bit 1 (gate) clear, `line_out` equals the serial bit of the previous cycle, whatever the carrier is doing.
- R3: A frame is one low start bit, then the eight data bits starting with bit 0, then one high stop bit. Each bit lasts DIV+1 cycles, where DIV is the value written at address 0. Between frames the serial bit is 1.
- R4: With control bit 1 set, `line_out` equals the serial bit AND the carrier, both taken from the previous cycle.
- R5: While control bit 0 (run) is set, the carrier counter steps 0,1,…,MOD and then returns to 0, where MOD is written at address 1. The carrier is high exactly while the count is below CMP, written at address 2.
- R6: CMP = 0 keeps the carrier low all the time. CMP > MOD keeps it high all the time.
- R7: With control bit 0 clear, the counter holds at 0 and the carrier is low. With gating on, `line_out` is then low.
- R8: A `tx_wr` pulse while `tx_busy` is 1 changes neither the frame in flight nor the line after it. This includes a pulse at the edge that ends the stop bit.
- R9: `tx_busy` rises in the cycle after an accepted write and stays high for exactly 10·(DIV+1) cycles.
- R10: New MOD or CMP values written while the carrier runs take effect only at the next wrap of the counter to 0. While the carrier is stopped they load at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | CFG_W | Configuration write data |
| tx_wr | input | 1 | Byte write strobe |
| tx_data | input | 8 | Byte to send |
| tx_busy | output | 1 | Frame in flight |
| line_out | output | 1 | Registered serial output line |

## Verification
The bench runs every carrier terminal count from 0 to 3 against every compare threshold from 0 to two above it. This covers the all-dark and all-lit thresholds. A design with an off-by-one compare, or an off-by-one wrap, would show a lit slot too many or too few per period. Frames are sent with gating on, with gating off while the carrier runs, and with gating on while the carrier is stopped. A design that gated in the wrong mode, or that let a stopped carrier pass the line through, would put carrier pulses in plain frames or leave a line that should be dark high. Writes aimed at a busy transmitter arrive mid-frame and on the very edge where the stop bit ends. A design that took either write would restart or extend the frame. A compare change made mid-period has to wait for the wrap; applying it at once would reshape the pulse that is already running.

// File: rtl/cmtx_pkg.sv
package cmtx_pkg;
  typedef enum logic [1:0] {
    REG_DIV  = 2'd0,
    REG_MOD  = 2'd1,
    REG_CMP  = 2'd2,
    REG_CTRL = 2'd3
  } cfg_addr_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_GATE_BIT = 1;
  localparam int FRAME_BITS    = 10;
  localparam int DATA_BITS     = 8;
endpackage

// File: rtl/cmtx_regs.sv
module cmtx_regs #(
  parameter int CFG_W = 16,
  parameter int DIV_W = 16,
  parameter int PWM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [DIV_W-1:0] div_q,
  output logic [PWM_W-1:0] mod_q,
  output logic [PWM_W-1:0] cmp_q,
  output logic             run_q,
  output logic             gate_q
);
  import cmtx_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      mod_q  <= '0;
      cmp_q  <= '0;
      run_q  <= 1'b0;
      gate_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr_e'(cfg_addr))
        REG_DIV:  div_q <= cfg_wdata[DIV_W-1:0];
        REG_MOD:  mod_q <= cfg_wdata[PWM_W-1:0];
        REG_CMP:  cmp_q <= cfg_wdata[PWM_W-1:0];
        REG_CTRL: begin
          run_q  <= cfg_wdata[CTRL_RUN_BIT];
          gate_q <= cfg_wdata[CTRL_GATE_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmtx_tx.sv
module cmtx_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  input  logic [DIV_W-1:0] div,
  output logic             busy,
  output logic             ser
);
  import cmtx_pkg::*;

  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic [DATA_BITS:0] shift_q;
  logic [IDX_W-1:0]   idx_q;
  logic [DIV_W-1:0]   baud_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '1;
      idx_q   <= '0;
      baud_q  <= '0;
      busy    <= 1'b0;
      ser     <= 1'b1;
    end else if (!busy) begin
      if (tx_wr) begin
        shift_q <= {1'b1, tx_data};
        idx_q   <= '0;
        baud_q  <= '0;
        busy    <= 1'b1;
        ser     <= 1'b0;
      end
    end else if (baud_q == div) begin
      baud_q <= '0;
      if (idx_q == LAST_IDX) begin
        busy <= 1'b0;
        ser  <= 1'b1;
      end else begin
        idx_q   <= idx_q + 1'b1;
        ser     <= shift_q[0];
        shift_q <= {1'b1, shift_q[DATA_BITS:1]};
      end
    end else begin
      baud_q <= baud_q + 1'b1;
    end
  end
endmodule

// File: rtl/cmtx_pwm.sv
module cmtx_pwm #(
  parameter int PWM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PWM_W-1:0] mod_in,
  input  logic [PWM_W-1:0] cmp_in,
  output logic             carrier,
  output logic [PWM_W-1:0] cnt,
  output logic [PWM_W-1:0] mod_act,
  output logic [PWM_W-1:0] cmp_act
);
  logic reload;

  assign reload  = !run || (cnt == mod_act);
  assign carrier = run && (cnt < cmp_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      mod_act <= '0;
      cmp_act <= '0;
    end else begin
      if (reload) begin
        cnt     <= '0;
        mod_act <= mod_in;
        cmp_act <= cmp_in;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmtx_mix.sv
module cmtx_mix (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  input  logic ser,
  input  logic carrier,
  output logic line_q
);
  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b1;
    else     line_q <= gate ? (ser & carrier) : ser;
  end
endmodule

// File: rtl/cmtx_top.sv
module cmtx_top #(
  parameter int CFG_W = 16,
  parameter int DIV_W = 16,
  parameter int PWM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  output logic             tx_busy,
  output logic             line_out
);
  logic [DIV_W-1:0] div_w;
  logic [PWM_W-1:0] mod_w, cmp_w, cnt_w, mod_act_w, cmp_act_w;
  logic             run_w, gate_w, ser_w, carrier_w;

  cmtx_regs #(.CFG_W(CFG_W), .DIV_W(DIV_W), .PWM_W(PWM_W)) i_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .div_q(div_w), .mod_q(mod_w), .cmp_q(cmp_w),
    .run_q(run_w), .gate_q(gate_w)
  );

  cmtx_tx #(.DIV_W(DIV_W)) i_tx (
    .clk(clk), .rst(rst), .tx_wr(tx_wr), .tx_data(tx_data), .div(div_w),
    .busy(tx_busy), .ser(ser_w)
  );

  cmtx_pwm #(.PWM_W(PWM_W)) i_pwm (
    .clk(clk), .rst(rst), .run(run_w), .mod_in(mod_w), .cmp_in(cmp_w),
    .carrier(carrier_w), .cnt(cnt_w), .mod_act(mod_act_w), .cmp_act(cmp_act_w)
  );

  cmtx_mix i_mix (
    .clk(clk), .rst(rst), .gate(gate_w), .ser(ser_w), .carrier(carrier_w),
    .line_q(line_out)
  );
endmodule

// File: rtl/cmtx_chk.sv
module cmtx_chk #(
  parameter int PWM_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_wr,
  input logic             tx_busy,
  input logic             line_out,
  input logic             ser,
  input logic             run,
  input logic             gate,
  input logic [PWM_W-1:0] cnt,
  input logic [PWM_W-1:0] mod_act,
  input logic [PWM_W-1:0] cmp_act
);
  AST_LINE_NEEDS_SER: assert property (@(posedge clk) disable iff (rst) line_out |-> $past(ser)); // R4
  AST_STOPPED_DARK: assert property (@(posedge clk) disable iff (rst) ($past(!run) && $past(gate)) |-> !line_out); // R7
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst) (tx_wr && !tx_busy) |=> tx_busy); // R9
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst) $rose(tx_busy) |-> !ser); // R3
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst) $fell(tx_busy) |-> ($past(ser) && ser)); // R3
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst) cnt <= mod_act); // R5
  AST_CMP_AT_WRAP: assert property (@(posedge clk) disable iff (rst) (cnt != '0) |-> $stable(cmp_act)); // R10
endmodule

bind cmtx_top cmtx_chk #(.PWM_W(PWM_W)) i_chk (
  .clk(clk), .rst(rst), .tx_wr(tx_wr), .tx_busy(tx_busy), .line_out(line_out),
  .ser(ser_w), .run(run_w), .gate(gate_w), .cnt(cnt_w), .mod_act(mod_act_w),
  .cmp_act(cmp_act_w)
);

// File: tb/test_cmtx_top.sv
`timescale 1ns/1ps
module test_cmtx_top;
  localparam int CFG_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_addr = '0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic             tx_wr = 1'b0;
  logic [7:0]       tx_data = '0;
  logic             tx_busy, line_out;

  cmtx_top i_cmtx_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_busy(tx_busy), .line_out(line_out)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;

  // expectation state, written by the stimulus tasks
  int   e_run = 0, M = 0, C = 0, Cnew = 0, w_chg = -1, k = -1, D = 1;
  bit   pwm_on = 0, g_mod = 0;
  logic [7:0] fdata = '0;

  function automatic logic ser_at(int s);
    if (k >= 0 && s >= k && s < k + 10*D) begin
      int b = (s - k) / D;
      if (b == 0) return 1'b0;
      if (b == 9) return 1'b1;
      return fdata[b-1];
    end
    return 1'b1;
  endfunction

  function automatic logic car_at(int s);
    int c = C;
    if (!pwm_on || s < e_run) return 1'b0;
    if (w_chg >= 0) begin
      int f = e_run + ((w_chg - e_run) / (M + 1) + 1) * (M + 1);
      if (s >= f) c = Cnew;
    end
    return ((s - e_run) % (M + 1)) < c;
  endfunction

  function automatic logic line_exp(int n);
    return g_mod ? (ser_at(n-1) & car_at(n-1)) : ser_at(n-1);
  endfunction

  function automatic logic busy_exp(int n);
    return (k >= 0 && n >= k && n < k + 10*D);
  endfunction

  task automatic check(bit ok, string req, logic act, logic exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d actual=%0b expected=%0b", req, cyc, act, exp);
    end
  endtask

  task automatic watch(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(line_out === line_exp(cyc), {req, " line"}, line_out, line_exp(cyc));
      check(tx_busy === busy_exp(cyc), "R9 busy", tx_busy, busy_exp(cyc));
    end
  endtask

  task automatic watch_until(int target, string req);
    while (cyc < target) watch(1, req);
  endtask

  task automatic cfg_write(input logic [1:0] a, input int d, output int edge_n);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = CFG_W'(d);
    @(posedge clk); #1;
    edge_n = cyc;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_div(int d);
    int en;
    cfg_write(2'd0, d - 1, en);
    D = d;
  endtask

  task automatic set_pwm(bit run, bit gate, int m, int c);
    int en;
    cfg_write(2'd3, 0, en);
    cfg_write(2'd1, m, en);
    cfg_write(2'd2, c, en);
    cfg_write(2'd3, {30'd0, gate, run}, en);
    pwm_on = run; g_mod = gate; M = m; C = c; e_run = en; w_chg = -1;
  endtask

  task automatic send(logic [7:0] d);
    @(negedge clk);
    tx_wr = 1'b1; tx_data = d;
    @(posedge clk); #1;
    k = cyc; fdata = d;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog R9 actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int en;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state
    check(line_out === 1'b1, "R1 line", line_out, 1'b1);
    check(tx_busy === 1'b0, "R1 busy", tx_busy, 1'b0);
    watch(4, "R1");

    // R2 R3: plain frames while the carrier runs ungated
    set_div(3);
    set_pwm(1, 0, 3, 2);
    foreach (fdata_list[i]) begin
      send(fdata_list[i]);
      watch(10*D + 3, "R2 R3");
    end

    // R4 R5 R6: near-exhaustive sweep of period and threshold
    set_div(2);
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c <= m + 2; c++) begin
        set_pwm(1, 1, m, c);
        watch(2*(m+1) + 2, "R5 R6");
        send(8'hA5 ^ 8'(m*16 + c));
        watch(10*D + 3, "R4");
      end
    end

    // R7: gating on, carrier stopped
    set_pwm(0, 1, 3, 2);
    watch(4, "R7");
    send(8'hFF);
    watch(10*D + 3, "R7");

    // R8 R9: writes aimed at a busy transmitter
    set_div(4);
    set_pwm(1, 0, 2, 1);
    send(8'h96);
    watch_until(k + 5, "R8");
    tx_wr = 1'b1; tx_data = 8'h00;
    watch(1, "R8");
    tx_wr = 1'b0;
    watch_until(k + 10*D - 1, "R8");
    tx_wr = 1'b1; tx_data = 8'h00;
    watch(1, "R8");
    tx_wr = 1'b0;
    watch(6, "R8");

    // R10: threshold change mid-period waits for the wrap
    set_div(2);
    set_pwm(1, 1, 4, 1);
    watch_until(e_run + 6, "R10");
    cfg_write(2'd2, 4, en);
    Cnew = 4; w_chg = en;
    watch(3*(M+1), "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [7:0] fdata_list [6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h01, 8'h80};
endmodule